// File: doc/BRIEF.md
# Minimum Command Spacing Limiter

This block sits beside a DRAM command scheduler and keeps two commands of one class at least a fixed number of clock cycles apart. Examples of such a class are row activations, or a write followed by a read. The scheduler raises `valid_i` in every cycle in which it issues a command of the class. The block answers with a registered `ready_o` flag. That flag says whether another command of the class may issue in the current cycle.

The spacing `SPACING` is fixed at elaboration. Each issued command reloads an internal down-counter, and `ready_o` is held low until that counter has run out. A spacing of one needs no wait at all, so `ready_o` is tied high. A spacing of zero is treated the same way. Choosing and decoding commands is left to the scheduler.

Top module: `cmd_spacing_limiter`

## Requirements
- R1: For SPACING of 2 or more, `ready_o` is 0 while `rst_ni` is low and in the first cycle after reset is released. It is 1 from the second cycle onward, provided `valid_i` was low at the first rising edge.
- R2: For SPACING = N of 2 or more, after a rising edge that samples `valid_i` = 1, `ready_o` is 0 for the next N-1 cycles.
- R3: For SPACING = N of 2 or more, if there is no further command, `ready_o` is 1 again exactly N cycles after the edge that sampled the command. Two accepted commands are therefore never closer than N cycles.
- R4: With SPACING = 1, `ready_o` is 1 in every cycle, including during reset, directly after a command, and under back-to-back commands.
- R5: A command sampled while `ready_o` is 0 restarts the N-1 cycle low window from that edge.
- R6: While `valid_i` stays low, a `ready_o` that is 1 stays 1.
- R7: With SPACING = 0, `ready_o` is 1 in every cycle, whatever `valid_i` and `rst_ni` do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all state changes on the rising edge |
| rst_ni | input | 1 | Synchronous active-low reset |
| valid_i | input | 1 | A command of the class is issued this cycle |
| ready_o | output | 1 | Registered: a command of the class may issue this cycle |

## Verification
Every result is due exactly one rising edge after the stimulus that causes it, because `ready_o` comes straight from a flop. The bench drives `valid_i` on the falling edge and reads `ready_o` on the next falling edge, which is one rising edge later. A command therefore shows up as `ready_o` = 0 on the very next sample, and the recovery for spacing N shows up on the N-th sample after the command. The expected-value table for spacing 4 and the directed sequences for spacings 0 through 3 are written out cycle by cycle on that basis.

// File: rtl/spc_pkg.sv
package spc_pkg;

    typedef enum logic [1:0] {
        SPC_OFF   = 2'd0,
        SPC_PASS  = 2'd1,
        SPC_TIMED = 2'd2
    } spc_mode_e;

    // Variant selected by the spacing value.
    function automatic spc_mode_e spc_mode(input int unsigned spacing);
        if (spacing == 0) return SPC_OFF;
        if (spacing == 1) return SPC_PASS;
        return SPC_TIMED;
    endfunction

    // Bits needed to hold spacing-1, never fewer than one.
    function automatic int unsigned spc_cnt_width(input int unsigned spacing);
        if (spacing <= 2) return 1;
        return $clog2(spacing);
    endfunction

endpackage

// File: rtl/spc_down_counter.sv
module spc_down_counter #(
    parameter int unsigned       CNT_W    = 2,
    parameter logic [CNT_W-1:0] LOAD_VAL = '1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic load_i,
    output logic last_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (load_i) begin
            state_d.cnt = LOAD_VAL;
        end else if (state_q.cnt != '0) begin
            state_d.cnt = state_q.cnt - ONE;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    // At most one count left: the wait ends at the coming edge.
    assign last_o = (state_q.cnt <= ONE);

endmodule

// File: rtl/spc_ready_flag.sv
module spc_ready_flag (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic issue_i,
    input  logic expire_i,
    output logic ready_o
);

    typedef struct packed {
        logic ready;
    } flag_state_t;

    flag_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (issue_i) begin
            state_d.ready = 1'b0;
        end else if (!state_q.ready && expire_i) begin
            state_d.ready = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign ready_o = state_q.ready;

endmodule

// File: rtl/cmd_spacing_limiter.sv
module cmd_spacing_limiter #(
    parameter int unsigned SPACING = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic valid_i,
    output logic ready_o
);

    import spc_pkg::*;

    localparam spc_mode_e   MODE  = spc_mode(SPACING);
    localparam int unsigned CNT_W = spc_cnt_width(SPACING);

    generate
        if (MODE == SPC_TIMED) begin : g_timed
            localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(SPACING - 1);

            logic expire;

            spc_down_counter #(
                .CNT_W    (CNT_W),
                .LOAD_VAL (LOAD_VAL)
            ) u_cnt (
                .clk_i  (clk_i),
                .rst_ni (rst_ni),
                .load_i (valid_i),
                .last_o (expire)
            );

            spc_ready_flag u_flag (
                .clk_i    (clk_i),
                .rst_ni   (rst_ni),
                .issue_i  (valid_i),
                .expire_i (expire),
                .ready_o  (ready_o)
            );
        end else begin : g_open
            // No wait between commands: the path is always open.
            logic unused_inputs;
            assign unused_inputs = ^{clk_i, rst_ni, valid_i};
            assign ready_o       = 1'b1;
        end
    endgenerate

endmodule

// File: rtl/spc_checker.sv
module spc_checker #(
    parameter int unsigned SPACING = 4
) (
    input logic clk_i,
    input logic rst_ni,
    input logic valid_i,
    input logic ready_o
);

    localparam int unsigned GW = $clog2(SPACING + 1) + 1;
    localparam logic [GW-1:0] LIMIT = GW'(SPACING);

    logic [GW-1:0] since_q;
    logic          seen_q;
    logic          fresh_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            since_q <= '0;
            seen_q  <= 1'b0;
            fresh_q <= 1'b1;
        end else begin
            fresh_q <= 1'b0;
            if (valid_i) begin
                since_q <= GW'(1);
                seen_q  <= 1'b1;
            end else if (since_q < LIMIT) begin
                since_q <= since_q + GW'(1);
            end
        end
    end

    generate
        if (SPACING >= 2) begin : g_timed_chk
            // R1
            reset_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                fresh_q |-> !ready_o);
            // R1
            reset_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (fresh_q && !valid_i) |=> ready_o);
            // R2
            window_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (seen_q && since_q < LIMIT) |-> !ready_o);
            // R3
            window_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (seen_q && since_q >= LIMIT) |-> ready_o);
            // R5
            restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (valid_i && !ready_o) |=> !ready_o);
        end else begin : g_open_chk
            // R4
            always_open_chk: assert property (@(posedge clk_i)
                ready_o);
            logic unused_chk;
            assign unused_chk = ^{since_q, seen_q, fresh_q};
        end
    endgenerate

    // R6
    idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ready_o && !valid_i) |=> ready_o);

endmodule

bind cmd_spacing_limiter spc_checker #(.SPACING(SPACING)) u_spc_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .ready_o (ready_o)
);

// File: tb/sim_cmd_spacing_limiter.sv
module sim_cmd_spacing_limiter;

    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 5000;
    localparam int  NVEC       = 24;

    // Spacing 4 walk: command pattern and the ready value due one edge later.
    localparam logic [0:NVEC-1] VEC_VALID = 24'b0100_0101_0000_1001_0001_0000;
    localparam logic [0:NVEC-1] VEC_READY = 24'b1000_1000_0011_0000_0010_0011;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vld4 = 1'b0;
    logic vlds = 1'b0;
    logic rdy4, rdy0, rdy1, rdy2, rdy3;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cmd_spacing_limiter #(.SPACING(4)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .valid_i(vld4), .ready_o(rdy4));
    cmd_spacing_limiter #(.SPACING(0)) u_s0 (
        .clk_i(clk), .rst_ni(rst_n), .valid_i(vlds), .ready_o(rdy0));
    cmd_spacing_limiter #(.SPACING(1)) u_s1 (
        .clk_i(clk), .rst_ni(rst_n), .valid_i(vlds), .ready_o(rdy1));
    cmd_spacing_limiter #(.SPACING(2)) u_s2 (
        .clk_i(clk), .rst_ni(rst_n), .valid_i(vlds), .ready_o(rdy2));
    cmd_spacing_limiter #(.SPACING(3)) u_s3 (
        .clk_i(clk), .rst_ni(rst_n), .valid_i(vlds), .ready_o(rdy3));

    task automatic check(input logic got, input logic exp, input string req);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: ready=%b expected %b", req, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: ready=x expected end of run");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(rdy4, 1'b0, "R1 in reset spacing 4");
        check(rdy2, 1'b0, "R1 in reset spacing 2");
        check(rdy1, 1'b1, "R4 in reset spacing 1");
        check(rdy0, 1'b1, "R7 in reset spacing 0");
        rst_n = 1'b1;
        check(rdy4, 1'b0, "R1 first cycle after reset");
        @(negedge clk);
        check(rdy4, 1'b1, "R1 up one edge after reset");
        check(rdy3, 1'b1, "R1 spacing 3 up");
        check(rdy2, 1'b1, "R1 spacing 2 up");

        // Table walk at spacing 4 (covers R2, R3, R5, R6)
        for (int i = 0; i < NVEC; i++) begin
            vld4 = VEC_VALID[i];
            @(negedge clk);
            check(rdy4, VEC_READY[i], $sformatf("R2 R3 R5 R6 table step %0d", i));
        end
        vld4 = 1'b0;

        // R6: long idle keeps ready up
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check(rdy4, 1'b1, "R6 idle hold");
        end

        // Single command on the small spacings
        vlds = 1'b1;
        @(negedge clk);
        check(rdy2, 1'b0, "R2 spacing 2 low");
        check(rdy3, 1'b0, "R2 spacing 3 low");
        check(rdy1, 1'b1, "R4 spacing 1 after command");
        check(rdy0, 1'b1, "R7 spacing 0 after command");
        vlds = 1'b0;
        @(negedge clk);
        check(rdy2, 1'b1, "R3 spacing 2 back");
        check(rdy3, 1'b0, "R2 spacing 3 second low");
        @(negedge clk);
        check(rdy3, 1'b1, "R3 spacing 3 back");

        // Back-to-back commands
        vlds = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(rdy1, 1'b1, "R4 back-to-back spacing 1");
            check(rdy0, 1'b1, "R7 back-to-back spacing 0");
            check(rdy2, 1'b0, "R5 spacing 2 held by repeats");
        end
        vlds = 1'b0;
        @(negedge clk);
        check(rdy2, 1'b1, "R3 spacing 2 after burst");
        check(rdy3, 1'b0, "R5 spacing 3 restarted window");
        @(negedge clk);
        check(rdy3, 1'b1, "R3 spacing 3 after burst");

        // R7: reset has no effect on spacing 0
        rst_n = 1'b0;
        @(negedge clk);
        check(rdy0, 1'b1, "R7 spacing 0 during reset");
        check(rdy3, 1'b0, "R1 spacing 3 during reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(rdy3, 1'b1, "R1 spacing 3 after second reset");

        finish_run();
    end

endmodule